// File: doc/BRIEF.md
# SCL Bit-Rate Generator

This block times the serial clock of a two-wire bus master from the system clock. A 3-bit clock-select value picks a power-of-two prescaler that runs from undivided up to divide-by-128. Two 5-bit registers hold the count for the low half and the count for the high half. Each half lasts its register count plus a fixed overhead in prescaled ticks. The overhead stands for the input synchronizer and the noise filter, and it is one tick longer when the prescaler is bypassed.

The block drives the clock line low through an open-drain style output. It watches the line through a two-stage synchronizer and a filter that rejects single-cycle pulses. The high count does not start until the filtered line is seen high, so a slave that holds the line low stretches the period. The byte engine receives a one-cycle strobe in the middle of each high count for sampling data, and one in the first cycle of each low half for changing data. A small register port writes the three settings and reads them back.

Top module: `scl_rate_gen`

## Requirements
- R1: Address 0 is the mode register. Clock-select sits in bits 6:4 and reads back there, with all other bits reading 0. A write changes clock-select only when bit 3 of the same write is 1. Otherwise the write leaves it unchanged.
- R2: Address 1 holds the low count and address 2 holds the high count, each in bits 4:0. Bits 7:5 of a write are ignored and always read back as 1. After reset the reads return 0x00, 0xFF and 0xFF for addresses 0, 1 and 2.
- R3: Read data is registered. It shows the register selected by the address in the cycle after that address is presented, and it holds its old value until then.
- R4: With clock-select 0, the line is driven low for exactly (low count + 4) system cycles.
- R5: With clock-select k > 0, the line is driven low for exactly (low count + 3) x 2^k system cycles.
- R6: On an unloaded bus, the line is released for 4 + (high count + overhead) x 2^k cycles. The overhead is 4 for k = 0 and 3 otherwise. The first 4 cycles are the synchronizer and filter latency.
- R7: The high count starts only after the filtered line reads high. A slave holding the line low for h extra cycles lengthens the released time by exactly h.
- R8: A single-cycle high pulse on the line while a slave holds it low does not start the high count.
- R9: A register count of 0 behaves as a count of 1.
- R10: change_stb is high for exactly one cycle per low half: the first cycle in which the line is driven low.
- R11: sample_stb is high for exactly one cycle per released half. It comes at released-cycle index 4 + floor((high count + overhead)/2) x 2^k.
- R12: When gen_en is low or soft_rst is high, the line is released in the next cycle and no strobe is issued. On return to enabled operation, a full-length low half starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_en | input | 1 | Generator enable |
| soft_rst | input | 1 | Clears the phase machine and counters; settings are kept |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 mode, 1 low count, 2 high count) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| scl_in | input | 1 | Sensed clock-line level |
| scl_drive_low | output | 1 | 1 pulls the clock line low |
| sample_stb | output | 1 | One-cycle strobe in the middle of the high count |
| change_stb | output | 1 | One-cycle strobe in the first low cycle |

## Verification
Read data is due one edge after the address is set, so the bench checks the old value just after setting the address and the new value at the next falling edge. Line timing is measured as run lengths of the drive output, sampled on falling edges. The first low cycle is the cycle after the phase machine's edge, and the released index counts from the first undriven cycle. Strobe positions are therefore compared as indices inside those runs. The expected lengths, including the 4-cycle filter latency and any stretch, are worked out by hand from the requirements and stored in the vector table.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOW   = 2'd1,
    PH_HWAIT = 2'd2,
    PH_HCNT  = 2'd3
  } phase_e;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_LOW  = 2'd1;
  localparam logic [1:0] ADDR_HIGH = 2'd2;

  localparam int WP_BIT  = 3;
  localparam int CKS_LSB = 4;

endpackage

// File: rtl/scl_rate_regs.sv
module scl_rate_regs
  import scl_gen_pkg::*;
#(
  parameter int CKS_W  = 3,
  parameter int PER_W  = 5,
  parameter int DATA_W = 8,
  parameter logic [PER_W-1:0] LOW_RST  = '1,
  parameter logic [PER_W-1:0] HIGH_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CKS_W-1:0]  cks,
  output logic [PER_W-1:0]  low_per,
  output logic [PER_W-1:0]  high_per
);

  localparam int CKS_TOP = CKS_LSB + CKS_W;

  logic [CKS_W-1:0]  cks_q;
  logic [PER_W-1:0]  low_q, high_q;
  logic [DATA_W-1:0] rd_n, rdata_q;
  logic              unused_wtop;

  assign unused_wtop = ^wdata[DATA_W-1:CKS_TOP];

  always_ff @(posedge clk) begin
    if (rst) begin
      cks_q  <= '0;
      low_q  <= LOW_RST;
      high_q <= HIGH_RST;
    end else if (we) begin
      case (addr)
        ADDR_MODE: if (wdata[WP_BIT]) cks_q <= wdata[CKS_LSB +: CKS_W];
        ADDR_LOW:  low_q  <= wdata[PER_W-1:0];
        ADDR_HIGH: high_q <= wdata[PER_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_n = '0;
    case (addr)
      ADDR_MODE: rd_n[CKS_LSB +: CKS_W] = cks_q;
      ADDR_LOW: begin
        rd_n = '1;
        rd_n[PER_W-1:0] = low_q;
      end
      ADDR_HIGH: begin
        rd_n = '1;
        rd_n[PER_W-1:0] = high_q;
      end
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) rdata_q <= rd_n;

  assign rdata    = rdata_q;
  assign cks      = cks_q;
  assign low_per  = low_q;
  assign high_per = high_q;

  // R1: a mode write without the protect bit keeps clock-select
  assert_wp_holds_R1: assert property (@(posedge clk) disable iff (rst)
    (we && addr == ADDR_MODE && !wdata[WP_BIT]) |=> $stable(cks_q));

  // R2: the unused top bits of a period register always read as ones
  assert_reserved_ones_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) == ADDR_LOW || $past(addr) == ADDR_HIGH) |->
      (rdata[DATA_W-1:PER_W] == '1));

endmodule

// File: rtl/scl_in_filter.sv
module scl_in_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  output logic scl_filt
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   filt_q;
  logic                   s_prev, s_last;

  assign s_prev = sync_q[SYNC_STAGES-2];
  assign s_last = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      filt_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], scl_in};
      if (s_prev == s_last) filt_q <= s_last;
    end
  end

  assign scl_filt = filt_q;

  // R8: the filtered level moves only after two matching samples
  assert_filter_two_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_q) |-> ($past(s_prev) == $past(s_last)));

endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int CKS_W = 3,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [CKS_W-1:0] cks,
  input  logic [CNT_W-1:0] target,
  output logic             done,
  output logic             mid
);

  localparam int PC_W = (1 << CKS_W) - 1;

  logic [PC_W-1:0]  pc_q, lim;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign lim  = PC_W'((PC_W + 1)'(1) << cks) - PC_W'(1);
  assign tick = (pc_q == lim);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pc_q  <= '0;
      cnt_q <= '0;
    end else if (run) begin
      if (tick) begin
        pc_q  <= '0;
        cnt_q <= cnt_q + CNT_W'(1);
      end else begin
        pc_q <= pc_q + PC_W'(1);
      end
    end
  end

  assign done = run && tick && (cnt_q == target - CNT_W'(1));
  assign mid  = run && tick && ((cnt_q + CNT_W'(1)) == (target >> 1));

  // R12: every timed half starts from a cleared prescaler and count
  assert_fresh_phase_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> (cnt_q == '0 && pc_q == '0));

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_gen_pkg::*;
#(
  parameter int CKS_W       = 3,
  parameter int PER_W       = 5,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int OVH_DIRECT  = 4,
  parameter int OVH_PRESC   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gen_en,
  input  logic              soft_rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              scl_in,
  output logic              scl_drive_low,
  output logic              sample_stb,
  output logic              change_stb
);

  localparam int CNT_W = $clog2((1 << PER_W) + OVH_DIRECT);

  logic [CKS_W-1:0] cks;
  logic [PER_W-1:0] low_per, high_per, per_sel, per_eff;
  logic [CNT_W-1:0] target, ovh;
  logic             filt, done, mid, active, run, clear;
  logic             change_q, sample_q;
  phase_e           state, state_n;

  scl_rate_regs #(
    .CKS_W(CKS_W), .PER_W(PER_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .cks(cks), .low_per(low_per), .high_per(high_per)
  );

  scl_in_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
    .clk(clk), .rst(rst), .scl_in(scl_in), .scl_filt(filt)
  );

  assign per_sel = (state == PH_HCNT) ? high_per : low_per;
  assign per_eff = (per_sel == '0) ? PER_W'(1) : per_sel;
  assign ovh     = (cks == '0) ? CNT_W'(OVH_DIRECT) : CNT_W'(OVH_PRESC);
  assign target  = CNT_W'(per_eff) + ovh;

  assign active = gen_en && !soft_rst;
  assign run    = (state == PH_LOW) || (state == PH_HCNT);
  assign clear  = (state_n != state) || !active;

  scl_phase_timer #(.CKS_W(CKS_W), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .clear(clear), .run(run), .cks(cks),
    .target(target), .done(done), .mid(mid)
  );

  always_comb begin
    state_n = state;
    if (!active) begin
      state_n = PH_IDLE;
    end else begin
      case (state)
        PH_IDLE:  state_n = PH_LOW;
        PH_LOW:   if (done) state_n = PH_HWAIT;
        PH_HWAIT: if (filt) state_n = PH_HCNT;
        PH_HCNT:  if (done) state_n = PH_LOW;
        default:  state_n = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= PH_IDLE;
      change_q <= 1'b0;
      sample_q <= 1'b0;
    end else begin
      state    <= state_n;
      change_q <= (state_n == PH_LOW) && (state != PH_LOW);
      sample_q <= active && (state == PH_HCNT) && mid;
    end
  end

  assign scl_drive_low = (state == PH_LOW);
  assign change_stb    = change_q;
  assign sample_stb    = sample_q;

  // R12: disabled or soft reset releases the line on the next cycle
  assert_release_off_R12: assert property (@(posedge clk) disable iff (rst)
    !active |=> !scl_drive_low);

  // R7: the high count begins only once the filtered line was high
  assert_hcnt_after_high_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(state == PH_HCNT) |-> $past(filt));

  // R10: the change strobe never lasts two cycles
  assert_change_single_R10: assert property (@(posedge clk) disable iff (rst)
    change_stb |=> !change_stb);

  // R11: sampling and changing never coincide
  assert_strobes_apart_R11: assert property (@(posedge clk) disable iff (rst)
    !(change_stb && sample_stb));

endmodule

// File: tb/sim_scl_rate_gen.sv
module sim_scl_rate_gen;

  typedef struct packed {
    logic [2:0]  cks;
    logic [4:0]  lo;
    logic [4:0]  hi;
    logic [15:0] exp_low;
    logic [15:0] exp_rel;
    logic [15:0] exp_smp;
  } vec_t;

  // expected values from R4/R5/R6/R9/R11
  localparam vec_t VEC [8] = '{
    '{3'd0, 5'd1,  5'd1,  16'd5,   16'd9,   16'd6},
    '{3'd0, 5'd10, 5'd20, 16'd14,  16'd28,  16'd16},
    '{3'd1, 5'd1,  5'd2,  16'd8,   16'd14,  16'd8},
    '{3'd2, 5'd5,  5'd3,  16'd32,  16'd28,  16'd16},
    '{3'd0, 5'd31, 5'd31, 16'd35,  16'd39,  16'd21},
    '{3'd3, 5'd2,  5'd1,  16'd40,  16'd36,  16'd20},
    '{3'd0, 5'd0,  5'd0,  16'd5,   16'd9,   16'd6},
    '{3'd7, 5'd1,  5'd1,  16'd512, 16'd516, 16'd260}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       gen_en = 1'b0, soft_rst = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  logic       scl_in, scl_drive_low, sample_stb, change_stb;
  logic       slave_hold = 1'b0, glitch = 1'b0;

  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  assign scl_in = glitch | ~(scl_drive_low | slave_hold);

  scl_rate_gen u0 (
    .clk(clk), .rst(rst), .gen_en(gen_en), .soft_rst(soft_rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .scl_in(scl_in), .scl_drive_low(scl_drive_low),
    .sample_stb(sample_stb), .change_stb(change_stb)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected below 150000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    @(negedge clk);
    v = int'(reg_rdata);
  endtask

  task automatic setup(input logic [2:0] k, input logic [4:0] lo, input logic [4:0] hi);
    gen_en = 1'b0;
    @(negedge clk);
    wr(2'd0, {1'b0, k, 1'b1, 3'b000});
    wr(2'd1, {3'b000, lo});
    wr(2'd2, {3'b000, hi});
    gen_en = 1'b1;
  endtask

  // measures one low half and the released half after it
  task automatic measure(input int hold_until, input int glitch_at,
                         output int lo_len, output int rel_len,
                         output int smp_at, output int chg_n, output int smp_n);
    while (!scl_drive_low) @(negedge clk);
    if (hold_until > 0) slave_hold = 1'b1;
    lo_len = 0; chg_n = 0;
    while (scl_drive_low) begin
      if (change_stb) chg_n++;
      if (lo_len == 0 && !change_stb) chg_n = chg_n + 100;
      lo_len++;
      @(negedge clk);
    end
    rel_len = 0; smp_at = -1; smp_n = 0;
    while (!scl_drive_low) begin
      if (sample_stb) begin
        smp_n++;
        if (smp_at < 0) smp_at = rel_len;
      end
      if (rel_len == hold_until) slave_hold = 1'b0;
      glitch = (rel_len == glitch_at);
      rel_len++;
      @(negedge clk);
    end
    glitch = 1'b0; slave_hold = 1'b0;
  endtask

  initial begin
    int v, lo_len, rel_len, smp_at, chg_n, smp_n, old;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state, R2 and R12
    chk("R12 released after reset", int'(scl_drive_low), 0);
    rd(2'd0, v); chk("R2 mode reset", v, 8'h00);
    rd(2'd1, v); chk("R2 low reset", v, 8'hFF);
    rd(2'd2, v); chk("R2 high reset", v, 8'hFF);

    // R1 write protect
    wr(2'd0, 8'h20);
    rd(2'd0, v); chk("R1 unprotected write ignored", v, 8'h00);
    wr(2'd0, 8'h28);
    rd(2'd0, v); chk("R1 protected write taken", v, 8'h20);
    wr(2'd0, 8'h58);
    rd(2'd0, v); chk("R1 readback field", v, 8'h50);

    // R2 reserved bits
    wr(2'd1, 8'h05);
    rd(2'd1, v); chk("R2 low reads ones on top", v, 8'hE5);
    wr(2'd2, 8'h4A);
    rd(2'd2, v); chk("R2 high write top ignored", v, 8'hEA);

    // R3 read latency
    reg_addr = 2'd1;
    @(negedge clk);
    old = int'(reg_rdata);
    reg_addr = 2'd0;
    #1 chk("R3 old data held", int'(reg_rdata), old);
    @(negedge clk);
    chk("R3 new data next cycle", int'(reg_rdata), 8'h50);

    // vector table: R4 R5 R6 R9 R10 R11
    for (int i = 0; i < 8; i++) begin
      setup(VEC[i].cks, VEC[i].lo, VEC[i].hi);
      measure(0, -1, lo_len, rel_len, smp_at, chg_n, smp_n);
      chk((VEC[i].cks == 0) ? "R4 low length" : "R5 low length", lo_len, int'(VEC[i].exp_low));
      chk("R6 released length", rel_len, int'(VEC[i].exp_rel));
      chk("R11 sample index", smp_at, int'(VEC[i].exp_smp));
      chk("R11 one sample", smp_n, 1);
      chk("R10 one change at first low cycle", chg_n, 1);
      if (VEC[i].lo == 0) chk("R9 zero treated as one", lo_len, 5);
    end

    // R7 stretch, cks 0 low 1 high 1
    setup(3'd0, 5'd1, 5'd1);
    measure(6, -1, lo_len, rel_len, smp_at, chg_n, smp_n);
    chk("R7 stretch adds hold time", rel_len, 15);
    chk("R7 sample after stretch", smp_at, 12);
    chk("R7 low unchanged", lo_len, 5);

    // R8 single-cycle glitch during hold
    measure(8, 2, lo_len, rel_len, smp_at, chg_n, smp_n);
    chk("R8 glitch ignored", rel_len, 17);
    chk("R8 sample position", smp_at, 14);

    // R12 soft reset mid low half
    setup(3'd0, 5'd10, 5'd20);
    while (!scl_drive_low) @(negedge clk);
    repeat (3) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    chk("R12 soft reset releases", int'(scl_drive_low), 0);
    soft_rst = 1'b0;
    measure(0, -1, lo_len, rel_len, smp_at, chg_n, smp_n);
    chk("R12 full low after soft reset", lo_len, 14);
    chk("R12 full release after soft reset", rel_len, 28);

    // R12 disable in released half: no drive, no strobes
    repeat (2) @(negedge clk);
    gen_en = 1'b0;
    @(negedge clk);
    v = 0;
    for (int j = 0; j < 40; j++) begin
      if (scl_drive_low || sample_stb || change_stb) v++;
      @(negedge clk);
    end
    chk("R12 idle while disabled", v, 0);
    gen_en = 1'b1;
    measure(0, -1, lo_len, rel_len, smp_at, chg_n, smp_n);
    chk("R12 full low after enable", lo_len, 14);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule